// File: doc/BRIEF.md
# Cold/Warm Boot Vector Sequencer

This block sits in front of a small processor's instruction bus while the core leaves reset. It decides whether the start is a power-up (cold) or a later reset (warm). It reads one 32-bit word from a fixed address that depends on that choice. The word it reads is the address where execution begins. The block loads that word into the program counter and raises a run enable, which hands the bus back to normal instruction fetch.

The start-up path has two steps. The first address is fixed by parameters, and the boot ROM stores the real entry point at that address. The cold and warm slots are separate, so the boot ROM can skip its power-up work when the start follows a warm reset. A start address that is not word aligned is refused: the block stops with an error flag set and does not enable the core.

Top module: `boot_vector_seq`

## Requirements
- R1: While rst_ni is low, mem_req_o, run_o and err_o are 0 and pc_o is 0x00000000.
- R2: After rst_ni is released, the first read request goes to byte address 0x000FFFF4. The word returned becomes pc_o.
- R3: A pulse on warm_rst_i starts a fetch from byte address 0x000FFFF0. The word returned becomes pc_o.
- R4: The cold-start flag is set only by rst_ni and cleared by warm_rst_i. Repeated warm resets keep using 0x000FFFF0. A later rst_ni uses 0x000FFFF4 again.
- R5: mem_req_o stays high with a stable mem_addr_o until a cycle in which mem_gnt_i is high. Any number of wait cycles is allowed.
- R6: The word is captured only on a cycle in which mem_rvalid_i is high. Any read latency is accepted. run_o (or err_o) rises on the clock edge that samples mem_rvalid_i. That edge is G+R+3 edges after reset release, where G is the number of wait cycles before the grant and R is the number of cycles between the grant and mem_rvalid_i.
- R7: run_o is 0 for the whole fetch. Once run_o is high, it stays high and pc_o stays constant until the next reset.
- R8: A warm reset in the middle of a fetch abandons that fetch. No request is made while warm_rst_i is high. A fresh fetch from 0x000FFFF0 starts afterwards.
- R9: rst_ni has priority over warm_rst_i when both are active together. A warm_rst_i that is high while rst_ni is low does not clear the cold-start flag.
- R10: If bits [1:0] of the fetched word are not 00, err_o goes high. run_o and mem_req_o stay low until the next reset of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm reset, synchronous, active high |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Byte address of the vector slot |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pc_o | output | 32 | Start address loaded into the program counter |
| run_o | output | 1 | Core may run |
| err_o | output | 1 | Fetched start address is misaligned |

## Verification
The first request is due one edge after any reset is released. The request holds for G further edges until the grant. The result then appears on the edge that samples read-valid, so the total is G+R+3 edges after release. The bench counts edges from the falling edge on which it releases a reset and samples at each following falling edge. It checks that run_o or err_o first appears at exactly that count, and that the value captured at that moment equals the vector word, not the filler data the memory model drives on cycles without valid data.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_HALT  = 3'd4
  } bvs_state_e;

  localparam logic [31:0] DEF_COLD_SLOT = 32'h000F_FFF4;
  localparam logic [31:0] DEF_WARM_SLOT = 32'h000F_FFF0;
endpackage

// File: rtl/bvs_mode_reg.sv
module bvs_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_rst_i,
  output logic cold_o
);
  logic cold_q;

  // async power-on reset dominates any warm request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cold_q <= 1'b1;
    else if (warm_rst_i) cold_q <= 1'b0;
  end

  assign cold_o = cold_q;

  p_warm_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !cold_o);
  p_cold_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cold_o && !warm_rst_i) |=> !cold_o);
endmodule

// File: rtl/bvs_pc_reg.sv
module bvs_pc_reg #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= data_i;
  end

  assign pc_o       = pc_q;
  assign misalign_o = |data_i[ALIGN_BITS-1:0];

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> pc_o == $past(pc_o));
endmodule

// File: rtl/bvs_fetch_fsm.sv
module bvs_fetch_fsm
  import boot_vec_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] COLD_SLOT = DEF_COLD_SLOT,
  parameter logic [31:0] WARM_SLOT = DEF_WARM_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              cold_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  input  logic              misalign_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              load_o,
  output logic              run_o,
  output logic              err_o
);
  bvs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (warm_rst_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ISSUE;
        ST_ISSUE: if (gnt_i) state_d = ST_WAIT;
        ST_WAIT:  if (rvalid_i) state_d = misalign_i ? ST_HALT : ST_RUN;
        ST_RUN:   state_d = ST_RUN;
        ST_HALT:  state_d = ST_HALT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o  = (state_q == ST_ISSUE);
  assign addr_o = cold_i ? COLD_SLOT[ADDR_W-1:0] : WARM_SLOT[ADDR_W-1:0];
  assign load_o = (state_q == ST_WAIT) && rvalid_i && !warm_rst_i;
  assign run_o  = (state_q == ST_RUN);
  assign err_o  = (state_q == ST_HALT);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !warm_rst_i) |=> (req_o && $stable(addr_o)));
  p_no_req_warm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !req_o && !run_o && !err_o);
  p_run_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_o && (req_o || err_o)));
  p_run_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !warm_rst_i) |=> run_o);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !warm_rst_i) |=> (err_o && !req_o));
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
  import boot_vec_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          ALIGN_BITS = 2,
  parameter logic [31:0] COLD_SLOT  = DEF_COLD_SLOT,
  parameter logic [31:0] WARM_SLOT  = DEF_WARM_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              run_o,
  output logic              err_o
);
  logic cold, load, misalign;

  bvs_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .cold_o     (cold)
  );

  bvs_pc_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .data_i     (mem_rdata_i),
    .pc_o       (pc_o),
    .misalign_o (misalign)
  );

  bvs_fetch_fsm #(.ADDR_W(ADDR_W), .COLD_SLOT(COLD_SLOT), .WARM_SLOT(WARM_SLOT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .cold_i     (cold),
    .gnt_i      (mem_gnt_i),
    .rvalid_i   (mem_rvalid_i),
    .misalign_i (misalign),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o),
    .load_o     (load),
    .run_o      (run_o),
    .err_o      (err_o)
  );

  p_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o == COLD_SLOT[ADDR_W-1:0] || mem_addr_o == WARM_SLOT[ADDR_W-1:0]));
  p_pc_from_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> pc_o == $past(mem_rdata_i));
  p_aligned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> pc_o[ALIGN_BITS-1:0] == '0);
endmodule

// File: tb/boot_vector_seq_tb.sv
module boot_vector_seq_tb;
  localparam logic [31:0] COLD_A = 32'h000F_FFF4;
  localparam logic [31:0] WARM_A = 32'h000F_FFF0;
  localparam logic [31:0] FILL   = 32'hA5A5_A5A5;

  typedef struct packed {
    logic        warm;
    logic [31:0] word;
    logic [3:0]  g;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1230, 4'd0, 4'd0},
    '{1'b1, 32'h0000_3210, 4'd0, 4'd0},
    '{1'b1, 32'h0004_0000, 4'd3, 4'd2},
    '{1'b0, 32'h000A_BCDC, 4'd2, 4'd5},
    '{1'b1, 32'h000F_FF00, 4'd1, 4'd7},
    '{1'b0, 32'h0000_0010, 4'd5, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm = 1'b0;
  logic        req, gnt, rvalid, run, err;
  logic [31:0] addr, rdata, pc;

  int          g_lat = 0, r_lat = 0;
  logic [31:0] cold_word = 32'h0, warm_word = 32'h0;
  int          wcnt, rcnt;
  logic        pend;
  logic [31:0] pend_addr, acc_addr;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  boot_vector_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm),
    .mem_req_o(req), .mem_addr_o(addr), .mem_gnt_i(gnt),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .pc_o(pc), .run_o(run), .err_o(err)
  );

  // memory model
  assign gnt    = req && (wcnt >= g_lat);
  assign rvalid = pend && (rcnt == 0);
  assign rdata  = !rvalid ? FILL :
                  (pend_addr == COLD_A) ? cold_word :
                  (pend_addr == WARM_A) ? warm_word : 32'hDEAD_BEEF;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni || warm) begin
      wcnt <= 0; pend <= 1'b0; rcnt <= 0; pend_addr <= '0;
    end else begin
      wcnt <= (req && !gnt) ? wcnt + 1 : 0;
      if (req && gnt) begin
        pend <= 1'b1; rcnt <= r_lat; pend_addr <= addr; acc_addr <= addr;
      end else if (pend) begin
        if (rcnt == 0) pend <= 1'b0;
        else           rcnt <= rcnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic do_warm();
    @(negedge clk); warm = 1'b1;
    @(negedge clk); warm = 1'b0;
  endtask

  // counts edges after release until run/err; returns count or -1
  task automatic wait_done(output int n);
    n = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (run || err) begin n = k; break; end
    end
  endtask

  task automatic run_case(input vec_t v, input string tag);
    int n, exp_n;
    logic [31:0] exp_a;
    g_lat = int'(v.g); r_lat = int'(v.r);
    if (v.warm) warm_word = v.word; else cold_word = v.word;
    if (v.warm) do_warm(); else do_por();
    wait_done(n);
    exp_n = g_lat + r_lat + 3;
    exp_a = v.warm ? WARM_A : COLD_A;
    check(n == exp_n, {tag, " R6 latency"}, n, exp_n);
    check(acc_addr == exp_a, v.warm ? {tag, " R3 warm slot"} : {tag, " R2 cold slot"}, acc_addr, exp_a);
    check(pc == v.word && run == (v.word[1:0] == 2'b00), {tag, " R2 pc/run"}, pc, v.word);
    check(err == (v.word[1:0] != 2'b00), {tag, " R10 err"}, {31'b0, err}, {31'b0, v.word[1:0] != 2'b00});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pc_hold;
    int n;
    // R1 reset state
    repeat (2) @(negedge clk);
    check(!req && !run && !err && pc == 32'h0, "R1 reset state", {28'b0, req, run, err, 1'b0}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) run_case(VECS[i], $sformatf("vec%0d", i));

    // R7 pc and run stable once running
    pc_hold = pc;
    repeat (5) @(negedge clk);
    check(run && pc == pc_hold && !req, "R7 hold", pc, pc_hold);

    // R4 repeated warm keeps warm slot
    warm_word = 32'h0002_2220; g_lat = 0; r_lat = 1;
    do_warm(); wait_done(n);
    check(acc_addr == WARM_A, "R4 warm after warm", acc_addr, WARM_A);
    do_warm(); wait_done(n);
    check(acc_addr == WARM_A && pc == 32'h0002_2220, "R4 second warm", acc_addr, WARM_A);

    // R8 warm reset abandons a cold fetch in WAIT
    cold_word = 32'h0000_7000; warm_word = 32'h0000_8000; g_lat = 0; r_lat = 6;
    do_por();
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(!run && !req, "R8 mid-fetch (waiting)", {31'b0, run}, 32'h0);
    warm = 1'b1;
    @(negedge clk);
    check(!req && !run, "R8 no request during warm", {31'b0, req}, 32'h0);
    @(negedge clk);
    check(!req, "R8 warm held", {31'b0, req}, 32'h0);
    warm = 1'b0;
    wait_done(n);
    check(n == 0 + 6 + 3, "R8 restart latency", n, 9);
    check(acc_addr == WARM_A && pc == 32'h0000_8000, "R8 restart warm slot", pc, 32'h0000_8000);

    // R9 warm during POR does not clear cold flag
    cold_word = 32'h0000_9000; g_lat = 1; r_lat = 1;
    @(negedge clk); rst_ni = 1'b0; warm = 1'b1;
    @(negedge clk);
    check(!req && !run && !err && pc == 0, "R9 por wins", pc, 32'h0);
    @(negedge clk); rst_ni = 1'b1; warm = 1'b0;
    wait_done(n);
    check(acc_addr == COLD_A && pc == 32'h0000_9000, "R9 cold slot kept", acc_addr, COLD_A);

    // R10 misaligned halts, warm recovers
    warm_word = 32'h0000_1232; g_lat = 2; r_lat = 1;
    do_warm(); wait_done(n);
    check(n == 6 && err && !run, "R10 misaligned", n, 6);
    repeat (4) @(negedge clk);
    check(err && !run && !req, "R10 halt sticky", {30'b0, err, req}, 32'h2);
    warm_word = 32'h0000_1234; g_lat = 0; r_lat = 0;
    do_warm(); wait_done(n);
    check(run && !err && pc == 32'h0000_1234, "R10 recovery", pc, 32'h0000_1234);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule